// File: doc/BRIEF.md
# Blocked LU Loop Index Generator

This block walks the index space of a column-blocked LU factorisation in which K adjacent columns are handled together. After a start request it emits one tuple (i, k, j) per accepted clock. The row index i is the outer loop and runs from 1 up to the matrix order N. The block offset k is the middle loop. It begins at the K-aligned block that holds column i and advances by K. The inner index j runs from i to N. Downstream address generation, memory and arithmetic units consume the tuples. They throttle the stream with a ready input and learn that the walk has finished from a one-cycle done pulse.

N arrives on an input and is captured when a start is accepted. K is a compile-time parameter and must be a power of two. N is taken to be a power of two in 16..128 with N ≥ K. Inside, a control state machine sits beside a set of index counters, followed by a two-stage register pipeline. Stalls are global: while ready is low, the counters and both pipeline stages hold.

The control state machine has four states. IDLE waits and takes start into RUN, loading the counters. RUN holds while the counters produce tuples and moves to DRAIN when the final counter state is accepted into the pipeline. DRAIN holds until the final tuple is accepted at the output and then moves to FINISH. FINISH asserts done for one cycle and always returns to IDLE.

Top module: `lu_loop_idxgen`

## Requirements
- R1: After reset, valid_o and done_o are low and no tuple is produced until a start is accepted.
- R2: Tuples appear in nested order: i ascending from 1 to N outermost, then k, then j innermost. The i_o field carries the row index.
- R3: For each i, k_o takes the values floor((i-1)/K)*K, then that value plus K, and so on up to N-K. N-K is the largest multiple of K not exceeding N+1-K.
- R4: For each (i, k), j_o takes every value from i to N in ascending order.
- R5: With ready_i held high, start_i is sampled high in IDLE at edge t0 and valid_o first goes high right after edge t0+2. The counter state loaded at t0 reaches the outputs through two register stages.
- R6: While valid_o is high and ready_i is low, the next edge keeps valid_o high and i_o, k_o and j_o unchanged.
- R7: done_o is high for exactly the one cycle after the edge that accepts the final tuple (i=N, k=N-K, j=N). valid_o is low in that cycle.
- R8: A start_i pulse in RUN, DRAIN or FINISH is ignored. The running sequence is unaffected, and no tuples follow done_o.
- R9: n_i is captured when start is accepted. Changes on n_i during a run do not alter the sequence.
- R10: With ready_i held high, tuples arrive back to back with no bubbles. done_o therefore appears T cycles after the first valid tuple, where T is the total tuple count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Requests a new walk; honoured only in IDLE |
| n_i | input | IW | Matrix order N, captured at start |
| ready_i | input | 1 | Downstream accepts the current tuple; low stalls the whole block |
| valid_o | output | 1 | A tuple is presented on i_o, k_o, j_o |
| i_o | output | IW | Row index i (1..N) |
| k_o | output | IW | Block column offset k (multiple of K) |
| j_o | output | IW | Inner index j (i..N) |
| done_o | output | 1 | One-cycle pulse after the final tuple is accepted |

## Verification
A counter that wraps early or late makes the output stream diverge at the next tuple. The scoreboard catches this on the very tuple where the divergence begins, so a wrong k start block or a wrong j reload shows within one accepted tuple of the faulty transition. A state machine that leaves DRAIN too soon or too late moves done_o away from the cycle right after the last accepted tuple, and the mismatch is flagged in that cycle. If a stall lets state slip, the output tuple changes while ready_i is low, which is seen one edge later.

// File: rtl/lu_idx_pkg.sv
package lu_idx_pkg;

    // Control states of the index generator
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_DRAIN  = 2'd2,
        ST_FINISH = 2'd3
    } gen_state_e;

endpackage

// File: rtl/lu_idx_counter.sv
module lu_idx_counter #(
    parameter int K  = 8,
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [IW-1:0] n_i,
    input  logic          step_i,
    output logic          active_o,
    output logic          last_o,
    output logic [IW-1:0] i_o,
    output logic [IW-1:0] k_o,
    output logic [IW-1:0] j_o
);

    localparam int KW = $clog2(K);
    localparam logic [IW-1:0] KSTEP = IW'(K);
    localparam logic [IW-1:0] KMASK = IW'(K - 1);

    logic [IW-1:0] n_q;
    logic [IW-1:0] kmax_q;
    logic [IW-1:0] i_q, k_q, j_q;
    logic          active_q;

    logic j_wrap, k_wrap, i_wrap;

    // Start of the K-aligned block that holds a zero-based column
    function automatic logic [IW-1:0] blk_base(input logic [IW-1:0] col0);
        return col0 & ~KMASK;
    endfunction

    always_comb begin
        j_wrap = (j_q == n_q);
        k_wrap = (k_q == kmax_q);
        i_wrap = (i_q == n_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q      <= '0;
            kmax_q   <= '0;
            i_q      <= '0;
            k_q      <= '0;
            j_q      <= '0;
            active_q <= 1'b0;
        end else if (load_i) begin
            n_q      <= n_i;
            kmax_q   <= n_i - KSTEP;
            i_q      <= IW'(1);
            k_q      <= '0;
            j_q      <= IW'(1);
            active_q <= 1'b1;
        end else if (step_i && active_q) begin
            if (!j_wrap) begin
                j_q <= j_q + IW'(1);
            end else if (!k_wrap) begin
                k_q <= k_q + KSTEP;
                j_q <= i_q;
            end else if (!i_wrap) begin
                i_q <= i_q + IW'(1);
                j_q <= i_q + IW'(1);
                k_q <= blk_base(i_q);
            end else begin
                active_q <= 1'b0;
            end
        end
    end

    always_comb begin
        active_o = active_q;
        last_o   = active_q && i_wrap && k_wrap && j_wrap;
        i_o      = i_q;
        k_o      = k_q;
        j_o      = j_q;
    end

    AST_CNT_I_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (i_q >= IW'(1) && i_q <= n_q)); // R2

    AST_CNT_K_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (k_q[KW-1:0] == '0 && k_q <= kmax_q)); // R3

    AST_CNT_K_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> ({1'b0, k_q} + (IW+1)'(K) >= {1'b0, i_q})); // R3

    AST_CNT_J_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (j_q >= i_q && j_q <= n_q)); // R4

    AST_CNT_N_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !load_i) |=> $stable(n_q)); // R9

endmodule

// File: rtl/lu_idx_pipe.sv
module lu_idx_pipe #(
    parameter int DW     = 25,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          vld_i,
    input  logic [DW-1:0] data_i,
    output logic          vld_o,
    output logic [DW-1:0] data_o
);

    logic          vld_q [STAGES];
    logic [DW-1:0] dat_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                vld_q[s] <= 1'b0;
                dat_q[s] <= '0;
            end
        end else if (en_i) begin
            vld_q[0] <= vld_i;
            dat_q[0] <= data_i;
            for (int s = 1; s < STAGES; s++) begin
                vld_q[s] <= vld_q[s-1];
                dat_q[s] <= dat_q[s-1];
            end
        end
    end

    always_comb begin
        vld_o  = vld_q[STAGES-1];
        data_o = dat_q[STAGES-1];
    end

    AST_PIPE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> ($stable(vld_o) && $stable(data_o))); // R6

endmodule

// File: rtl/lu_idx_fsm.sv
module lu_idx_fsm
    import lu_idx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic adv_i,
    input  logic cnt_active_i,
    input  logic cnt_last_i,
    input  logic out_valid_i,
    input  logic out_last_i,
    output logic load_o,
    output logic done_o
);

    gen_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_RUN;
            ST_RUN:    if (cnt_active_i && cnt_last_i && adv_i) state_d = ST_DRAIN;
            ST_DRAIN:  if (out_valid_i && out_last_i && adv_i) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load_o = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   load_o = start_i;
            ST_RUN:    ;
            ST_DRAIN:  ;
            ST_FINISH: done_o = 1'b1;
            default:   ;
        endcase
    end

    AST_FSM_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_FSM_DRAIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |-> !cnt_active_i); // R8

    AST_FSM_RUN_COUNTING: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> cnt_active_i); // R8

endmodule

// File: rtl/lu_loop_idxgen.sv
module lu_loop_idxgen #(
    parameter int K    = 8,
    parameter int NMAX = 128,
    parameter int IW   = $clog2(NMAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [IW-1:0] n_i,
    input  logic          ready_i,
    output logic          valid_o,
    output logic [IW-1:0] i_o,
    output logic [IW-1:0] k_o,
    output logic [IW-1:0] j_o,
    output logic          done_o
);

    localparam int LAT = 2;
    localparam int DW  = 3 * IW + 1;

    logic          load;
    logic          cnt_active, cnt_last;
    logic [IW-1:0] cnt_i, cnt_k, cnt_j;
    logic [DW-1:0] pipe_in, pipe_out;
    logic          pipe_vld;
    logic          out_last;

    lu_idx_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .adv_i        (ready_i),
        .cnt_active_i (cnt_active),
        .cnt_last_i   (cnt_last),
        .out_valid_i  (pipe_vld),
        .out_last_i   (out_last),
        .load_o       (load),
        .done_o       (done_o)
    );

    lu_idx_counter #(.K(K), .IW(IW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .n_i      (n_i),
        .step_i   (ready_i),
        .active_o (cnt_active),
        .last_o   (cnt_last),
        .i_o      (cnt_i),
        .k_o      (cnt_k),
        .j_o      (cnt_j)
    );

    assign pipe_in = {cnt_last, cnt_i, cnt_k, cnt_j};

    lu_idx_pipe #(.DW(DW), .STAGES(LAT)) u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (ready_i),
        .vld_i  (cnt_active),
        .data_i (pipe_in),
        .vld_o  (pipe_vld),
        .data_o (pipe_out)
    );

    always_comb begin
        valid_o  = pipe_vld;
        out_last = pipe_out[DW-1];
        i_o      = pipe_out[3*IW-1:2*IW];
        k_o      = pipe_out[2*IW-1:IW];
        j_o      = pipe_out[IW-1:0];
    end

    AST_TOP_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(i_o) && $stable(k_o) && $stable(j_o))); // R6

    AST_TOP_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !valid_o); // R7

    AST_TOP_J_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (j_o >= i_o)); // R4

endmodule

// File: tb/lu_loop_idxgen_test.sv
module lu_loop_idxgen_test;

    localparam int K    = 8;
    localparam int NMAX = 128;
    localparam int IW   = 8;

    typedef struct {
        int i;
        int k;
        int j;
    } tup_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [IW-1:0] n_drv = IW'(16);
    logic          ready = 1'b1;
    logic          valid;
    logic [IW-1:0] i_out, k_out, j_out;
    logic          done;

    always #5 clk = ~clk;

    lu_loop_idxgen #(.K(K), .NMAX(NMAX), .IW(IW)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .n_i     (n_drv),
        .ready_i (ready),
        .valid_o (valid),
        .i_o     (i_out),
        .k_o     (k_out),
        .j_o     (j_out),
        .done_o  (done)
    );

    int   checks = 0;
    int   fails  = 0;
    tup_t exp_q[$];
    bit   stall_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Ready pattern, changed just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ready = stall_mode ? (lfsr[0] | lfsr[2]) : 1'b1;
        end
    end

    // Monitor: pops the scoreboard as tuples are accepted
    initial begin
        bit   pend_done = 1'b0;
        bit   prev_stall = 1'b0;
        int   pi = 0, pk = 0, pj = 0;
        tup_t e;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (pend_done) begin
                    chk(done === 1'b1, "R7", "done after last tuple", int'(done), 1);
                    chk(valid === 1'b0, "R7", "valid during done", int'(valid), 0);
                    pend_done = 1'b0;
                end else if (done) begin
                    chk(1'b0, "R7", "unexpected done", 1, 0);
                end
                if (prev_stall) begin
                    chk(valid === 1'b1, "R6", "valid held in stall", int'(valid), 1);
                    chk(int'(i_out) == pi && int'(k_out) == pk && int'(j_out) == pj,
                        "R6", "tuple held in stall (j)", int'(j_out), pj);
                end
                if (valid && ready) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R8", "tuple beyond sequence", int'(j_out), -1);
                    end else begin
                        e = exp_q.pop_front();
                        chk(int'(i_out) == e.i, "R2", "i index", int'(i_out), e.i);
                        chk(int'(k_out) == e.k, "R3", "k index", int'(k_out), e.k);
                        chk(int'(j_out) == e.j, "R4", "j index", int'(j_out), e.j);
                        if (exp_q.size() == 0) pend_done = 1'b1;
                    end
                end
                prev_stall = valid && !ready;
                pi = int'(i_out);
                pk = int'(k_out);
                pj = int'(j_out);
            end
        end
    end

    // Driver: fills the scoreboard, then starts one walk
    task automatic run_seq(input int n, input bit stall, input int mode);
        int total;
        int cyc;
        for (int i = 1; i <= n; i++) begin
            for (int k = ((i - 1) / K) * K; k <= n + 1 - K; k += K) begin
                for (int j = i; j <= n; j++) begin
                    tup_t t;
                    t.i = i; t.k = k; t.j = j;
                    exp_q.push_back(t);
                end
            end
        end
        total = exp_q.size();
        stall_mode = stall;
        @(posedge clk);
        #1;
        n_drv = IW'(n);
        start = 1'b1;
        @(posedge clk);          // start sampled here
        #1;
        start = 1'b0;
        if (mode == 0) begin
            @(negedge clk);
            chk(valid === 1'b0, "R5", "valid one edge after start", int'(valid), 0);
            @(negedge clk);
            chk(valid === 1'b0, "R5", "valid two edges after start", int'(valid), 0);
            @(negedge clk);
            chk(valid === 1'b1, "R5", "valid three edges after start", int'(valid), 1);
            cyc = 0;
            while (!done) begin
                @(negedge clk);
                cyc++;
            end
            chk(cyc == total, "R10", "cycles from first tuple to done", cyc, total);
        end else if (mode == 1) begin
            repeat (40) @(posedge clk);
            #1;
            start = 1'b1;
            n_drv = IW'(128);    // R9: must not affect the running walk
            @(posedge clk);
            #1;
            start = 1'b0;
            while (!done) @(negedge clk);
        end else begin
            while (!done) @(negedge clk);
            start = 1'b1;        // R8: start in the done cycle is ignored
            @(posedge clk);
            #1;
            start = 1'b0;
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                chk(valid === 1'b0, "R8", "no tuples after done", int'(valid), 0);
            end
        end
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R10", "tuples left in scoreboard", exp_q.size(), 0);
        exp_q.delete();
        stall_mode = 1'b0;
        n_drv = IW'(16);
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(valid === 1'b0, "R1", "valid after reset", int'(valid), 0);
        chk(done === 1'b0, "R1", "done after reset", int'(done), 0);
        repeat (4) @(negedge clk);
        chk(valid === 1'b0, "R1", "valid idle without start", int'(valid), 0);
        run_seq(16, 1'b0, 0);
        run_seq(32, 1'b1, 1);
        run_seq(16, 1'b1, 2);
        run_seq(64, 1'b0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule